// File: doc/BRIEF.md
# Floating-Point Conditional Predicate Evaluator with Unordered Trap

This block settles the outcome of a floating-point conditional (branch, set or trap) from stored result flags: negative, zero and not-a-number. It sees a request strobe, a 6-bit predicate code, the busy state of the execution unit and, optionally, of a conversion unit, and a flag that marks an earlier exception as still pending. One clock after each strobe it returns one response. The response is one of four kinds: a retry (null) response, a request to take the pending exception before the instruction, a true/false result, or a request to take a trap for an unordered compare.

The checks run in a fixed order. Busy comes first, then a pending exception, then detection of an unordered operand, and only then is the predicate evaluated. An unordered operand can be flagged only for the predicates whose code has bit 4 set (the IEEE-nonaware and signalling group). When it is flagged, bit 7 of an 8-bit exception status byte is set, together with a sticky accrued invalid-operation bit. If the matching enable is set, a trap response is returned in place of the result. The status byte keeps its bits until a separate write port loads it.

Top module: `fp_cond_eval`

## Requirements
- R1: After reset, rsp_valid is 0, status_byte is 8'h00 and acc_iop is 0.
- R2: A request sampled at a clock edge gives exactly one response (rsp_valid=1 for one cycle) at the next edge. Without a request, rsp_valid stays 0.
- R3: If exec_busy is 1, or conv_busy is 1 while HAS_CONV=1, the response has rsp_kind=0 (null) with rsp_come_again=1 and rsp_int_ok=1. This holds whatever the pending flag and the condition flags are, and status_byte does not change.
- R4: If the units are idle and exc_pending=1, the response has rsp_kind=1 (take pre-instruction exception) and rsp_true=0, and status_byte does not change. In every response other than null, rsp_come_again and rsp_int_ok are 0.
- R5: With pred_code[5:4]=00 the result (rsp_kind=2) follows the low nibble: 0 F, 1 EQ=Z, 2 OGT=!(NaN|Z|N), 3 OGE=Z|!(NaN|N), 4 OLT=N&!NaN&!Z, 5 OLE=Z|(N&!NaN), 6 OGL=!(NaN|Z), 7 OR=!NaN, 8 UN=NaN, 9 UEQ=NaN|Z, A UGT=NaN|!(N|Z), B UGE=NaN|Z|!N, C ULT=NaN|(N&!Z), D ULE=NaN|Z|N, E NE=!Z, F T.
- R6: With pred_code[5:4]=01 the result uses the same low-nibble truth as R5: 0x10 SF is always false, 0x11 SEQ is Z, 0x12 GT, 0x13 GE, 0x14 LT, 0x15 LE, 0x16 GL, 0x17 GLE, 0x18 NGLE, 0x19 NGL, 0x1A NLE, 0x1B NLT, 0x1C NGE, 0x1D NGT, 0x1E SNE is !Z, and 0x1F ST is always true.
- R7: An idle, non-pending request with pred_code[5:4]=01 and flag_nan=1 sets status_byte bit 7 and acc_iop.
- R8: A request with pred_code[5:4] other than 01 never sets status_byte bit 7 or acc_iop, even when flag_nan=1.
- R9: When R7 applies and enable_bsun=1, the response is rsp_kind=3 (take exception) with rsp_true=0. When enable_bsun=0, the normal result of R6 is returned.
- R10: status_byte and acc_iop keep their values until stat_wr_en=1, which loads stat_wr_data and acc_wr_data at the next edge. If a bit-7 set from R7 falls in the same cycle as a write, bit 7 and acc_iop end up 1.
- R11: Codes with pred_code[5]=1 are reserved: they give rsp_kind=2 with rsp_true=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Evaluation request strobe |
| pred_code | input | 6 | Predicate select code |
| flag_n | input | 1 | Stored negative flag |
| flag_z | input | 1 | Stored zero flag |
| flag_nan | input | 1 | Stored not-a-number (unordered) flag |
| exec_busy | input | 1 | Execution unit busy |
| conv_busy | input | 1 | Conversion unit busy (used when HAS_CONV=1) |
| exc_pending | input | 1 | Earlier exception still pending |
| enable_bsun | input | 1 | Trap enable for the unordered-compare status bit |
| stat_wr_en | input | 1 | Status byte write strobe |
| stat_wr_data | input | 8 | Value loaded into the status byte |
| acc_wr_data | input | 1 | Value loaded into the accrued invalid bit |
| rsp_valid | output | 1 | Response present |
| rsp_kind | output | 2 | 0 null, 1 pre-instruction exception, 2 result, 3 take exception |
| rsp_come_again | output | 1 | Come-again bit of a null response |
| rsp_int_ok | output | 1 | Interrupts-allowed bit of a null response |
| rsp_true | output | 1 | Predicate outcome in a result response |
| status_byte | output | 8 | Exception status byte, bit 7 unordered compare |
| acc_iop | output | 1 | Accrued invalid-operation bit |

## Verification
The hardest case to reach from the ports is a bit-7 set that falls in the same cycle as a status write. The bench creates it by raising stat_wr_en with a zero value on the same edge as an unordered signalling request, then checks that bit 7 and the accrued bit survive. A second hard case is the priority ladder. A NaN operand on a signalling predicate must leave the status untouched whenever busy or pending masks it, so those requests are sent with every masking input stacked. The full predicate table is swept under four ordered flag patterns and under NaN, with the status cleared between steps so that each bit-7 change can be traced to one request.

// File: rtl/fpce_pkg.sv
package fpce_pkg;
    localparam int CODE_W   = 6;
    localparam int STAT_W   = 8;
    localparam int UNORD_BIT = 7;

    typedef enum logic [1:0] {
        RSP_NULL    = 2'd0,
        RSP_PRE_EXC = 2'd1,
        RSP_RESULT  = 2'd2,
        RSP_TRAP    = 2'd3
    } rsp_kind_e;
endpackage

// File: rtl/fpce_pred.sv
module fpce_pred
    import fpce_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              n,
    input  logic              z,
    input  logic              nan,
    output logic              truth,
    output logic              unord_cap
);
    logic base;

    always_comb begin
        unique case (code[3:0])
            4'h0: base = 1'b0;
            4'h1: base = z;
            4'h2: base = ~(nan | z | n);
            4'h3: base = z | ~(nan | n);
            4'h4: base = n & ~nan & ~z;
            4'h5: base = z | (n & ~nan);
            4'h6: base = ~(nan | z);
            4'h7: base = ~nan;
            4'h8: base = nan;
            4'h9: base = nan | z;
            4'hA: base = nan | ~(n | z);
            4'hB: base = nan | z | ~n;
            4'hC: base = nan | (n & ~z);
            4'hD: base = nan | z | n;
            4'hE: base = ~z;
            default: base = 1'b1;
        endcase
        truth     = base & ~code[5];
        unord_cap = (code[5:4] == 2'b01);
    end

    always_comb begin
        assert_reserved_false_R11: assert (!(code[5] && truth));
    end
endmodule

// File: rtl/fpce_gate.sv
module fpce_gate
    import fpce_pkg::*;
#(
    parameter bit HAS_CONV = 1'b1
) (
    input  logic      req,
    input  logic      exec_busy,
    input  logic      conv_busy,
    input  logic      pend,
    input  logic      unord_cap,
    input  logic      nan,
    input  logic      trap_en,
    input  logic      truth,
    output rsp_kind_e kind,
    output logic      truth_out,
    output logic      raise_unord
);
    logic busy;

    generate
        if (HAS_CONV) begin : g_two_units
            assign busy = exec_busy | conv_busy;
        end else begin : g_one_unit
            logic conv_unused;
            assign conv_unused = conv_busy;
            assign busy = exec_busy;
        end
    endgenerate

    logic hit;

    always_comb begin
        hit         = unord_cap & nan;
        kind        = RSP_RESULT;
        truth_out   = 1'b0;
        raise_unord = 1'b0;
        if (busy) begin
            kind = RSP_NULL;
        end else if (pend) begin
            kind = RSP_PRE_EXC;
        end else if (hit) begin
            raise_unord = req;
            if (trap_en) begin
                kind = RSP_TRAP;
            end else begin
                truth_out = truth;
            end
        end else begin
            truth_out = truth;
        end
    end

    always_comb begin
        assert_trap_needs_nan_R9: assert (!(kind == RSP_TRAP && !nan));
    end
endmodule

// File: rtl/fpce_status.sv
module fpce_status
    import fpce_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_unord,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    input  logic              acc_wr_data,
    output logic [STAT_W-1:0] stat,
    output logic              acc
);
    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic              acc;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.stat = wr_data;
            st_d.acc  = acc_wr_data;
        end
        if (set_unord) begin
            st_d.stat[UNORD_BIT] = 1'b1;
            st_d.acc             = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat = st_q.stat;
    assign acc  = st_q.acc;

    assert_bit7_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stat[UNORD_BIT] && !wr_en) |=> st_q.stat[UNORD_BIT]);
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        set_unord |=> (st_q.stat[UNORD_BIT] && st_q.acc));
endmodule

// File: rtl/fp_cond_eval.sv
module fp_cond_eval
    import fpce_pkg::*;
#(
    parameter bit HAS_CONV = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CODE_W-1:0] pred_code,
    input  logic              flag_n,
    input  logic              flag_z,
    input  logic              flag_nan,
    input  logic              exec_busy,
    input  logic              conv_busy,
    input  logic              exc_pending,
    input  logic              enable_bsun,
    input  logic              stat_wr_en,
    input  logic [STAT_W-1:0] stat_wr_data,
    input  logic              acc_wr_data,
    output logic              rsp_valid,
    output logic [1:0]        rsp_kind,
    output logic              rsp_come_again,
    output logic              rsp_int_ok,
    output logic              rsp_true,
    output logic [STAT_W-1:0] status_byte,
    output logic              acc_iop
);
    typedef struct packed {
        logic      valid;
        rsp_kind_e kind;
        logic      come_again;
        logic      int_ok;
        logic      truth;
    } rsp_t;

    rsp_t      rsp_d, rsp_q;
    logic      pred_truth, unord_cap;
    rsp_kind_e gate_kind;
    logic      gate_truth, raise_unord;

    fpce_pred u_pred (
        .code      (pred_code),
        .n         (flag_n),
        .z         (flag_z),
        .nan       (flag_nan),
        .truth     (pred_truth),
        .unord_cap (unord_cap)
    );

    fpce_gate #(.HAS_CONV(HAS_CONV)) u_gate (
        .req         (req_valid),
        .exec_busy   (exec_busy),
        .conv_busy   (conv_busy),
        .pend        (exc_pending),
        .unord_cap   (unord_cap),
        .nan         (flag_nan),
        .trap_en     (enable_bsun),
        .truth       (pred_truth),
        .kind        (gate_kind),
        .truth_out   (gate_truth),
        .raise_unord (raise_unord)
    );

    fpce_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_unord   (raise_unord),
        .wr_en       (stat_wr_en),
        .wr_data     (stat_wr_data),
        .acc_wr_data (acc_wr_data),
        .stat        (status_byte),
        .acc         (acc_iop)
    );

    always_comb begin
        rsp_d            = '0;
        rsp_d.valid      = req_valid;
        rsp_d.kind       = RSP_NULL;
        if (req_valid) begin
            rsp_d.kind       = gate_kind;
            rsp_d.truth      = gate_truth;
            rsp_d.come_again = (gate_kind == RSP_NULL);
            rsp_d.int_ok     = (gate_kind == RSP_NULL);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid      = rsp_q.valid;
    assign rsp_kind       = rsp_q.kind;
    assign rsp_come_again = rsp_q.come_again;
    assign rsp_int_ok     = rsp_q.int_ok;
    assign rsp_true       = rsp_q.truth;

    assert_one_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_null_on_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && exec_busy) |=> (rsp_kind == 2'd0 && rsp_come_again && rsp_int_ok));
    assert_busy_keeps_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && exec_busy && !stat_wr_en) |=> $stable(status_byte));
    assert_pending_keeps_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && exc_pending && !stat_wr_en) |=> $stable(status_byte));
    assert_no_unord_outside_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pred_code[5:4] != 2'b01 && !stat_wr_en) |=> $stable(status_byte));
    assert_nonnull_bits_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind != 2'd0) |-> (!rsp_come_again && !rsp_int_ok));
    assert_true_only_in_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind != 2'd2) |-> !rsp_true);
endmodule

// File: tb/fp_cond_eval_tb_top.sv
`timescale 1ns/1ps
module fp_cond_eval_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [5:0] pred_code = '0;
    logic       flag_n = 1'b0, flag_z = 1'b0, flag_nan = 1'b0;
    logic       exec_busy = 1'b0, conv_busy = 1'b0, exc_pending = 1'b0;
    logic       enable_bsun = 1'b0;
    logic       stat_wr_en = 1'b0;
    logic [7:0] stat_wr_data = '0;
    logic       acc_wr_data = 1'b0;
    logic       rsp_valid, rsp_come_again, rsp_int_ok, rsp_true, acc_iop;
    logic [1:0] rsp_kind;
    logic [7:0] status_byte;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fp_cond_eval dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .pred_code(pred_code),
        .flag_n(flag_n), .flag_z(flag_z), .flag_nan(flag_nan),
        .exec_busy(exec_busy), .conv_busy(conv_busy), .exc_pending(exc_pending),
        .enable_bsun(enable_bsun), .stat_wr_en(stat_wr_en),
        .stat_wr_data(stat_wr_data), .acc_wr_data(acc_wr_data),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_come_again(rsp_come_again),
        .rsp_int_ok(rsp_int_ok), .rsp_true(rsp_true),
        .status_byte(status_byte), .acc_iop(acc_iop)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic ref_truth(input logic [5:0] c, input logic n, input logic z, input logic u);
        logic r;
        if (c[5]) return 1'b0;
        case (c[3:0])
            4'h0: r = 0;
            4'h1: r = z;
            4'h2: r = !u && !z && !n;
            4'h3: r = z || (!u && !n);
            4'h4: r = n && !u && !z;
            4'h5: r = z || (n && !u);
            4'h6: r = !u && !z;
            4'h7: r = !u;
            4'h8: r = u;
            4'h9: r = u || z;
            4'hA: r = u || (!n && !z);
            4'hB: r = u || z || !n;
            4'hC: r = u || (n && !z);
            4'hD: r = u || z || n;
            4'hE: r = !z;
            default: r = 1;
        endcase
        return r;
    endfunction

    task automatic send(input logic [5:0] c, input logic n, input logic z, input logic u);
        @(negedge clk);
        pred_code = c; flag_n = n; flag_z = z; flag_nan = u; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic write_stat(input logic [7:0] d, input logic a);
        @(negedge clk);
        stat_wr_en = 1'b1; stat_wr_data = d; acc_wr_data = a;
        @(negedge clk);
        stat_wr_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 status", status_byte, 8'h00);
        chk("R1 acc", acc_iop, 0);
        @(negedge clk);
        chk("R2 idle no rsp", rsp_valid, 0);
    endtask

    task automatic t_busy();
        exec_busy = 1'b1; exc_pending = 1'b1;
        send(6'h12, 0, 0, 1);
        chk("R3 valid", rsp_valid, 1);
        chk("R3 kind null", rsp_kind, 0);
        chk("R3 come_again", rsp_come_again, 1);
        chk("R3 int_ok", rsp_int_ok, 1);
        chk("R3 status", status_byte, 8'h00);
        exec_busy = 1'b0; conv_busy = 1'b1;
        send(6'h1F, 0, 0, 1);
        chk("R3 conv kind", rsp_kind, 0);
        chk("R3 conv status", status_byte, 8'h00);
        conv_busy = 1'b0; exc_pending = 1'b0;
        @(negedge clk);
        chk("R2 single rsp", rsp_valid, 0);
    endtask

    task automatic t_pending();
        exc_pending = 1'b1;
        send(6'h1F, 0, 0, 1);
        chk("R4 kind", rsp_kind, 1);
        chk("R4 true", rsp_true, 0);
        chk("R4 come_again", rsp_come_again, 0);
        chk("R4 status", status_byte, 8'h00);
        chk("R4 acc", acc_iop, 0);
        exc_pending = 1'b0;
    endtask

    task automatic t_sweep_ordered();
        for (int c = 0; c < 32; c++) begin
            for (int p = 0; p < 4; p++) begin
                logic n, z;
                n = p[0]; z = p[1];
                send(c[5:0], n, z, 0);
                chk(c < 16 ? "R5 kind" : "R6 kind", rsp_kind, 2);
                chk(c < 16 ? "R5 truth" : "R6 truth", rsp_true, ref_truth(c[5:0], n, z, 0));
            end
        end
        chk("R8 status after ordered sweep", status_byte, 8'h00);
    endtask

    task automatic t_sweep_nan();
        enable_bsun = 1'b0;
        for (int c = 0; c < 32; c++) begin
            send(c[5:0], 0, 0, 1);
            chk(c < 16 ? "R5 nan truth" : "R9 nan result", rsp_true, ref_truth(c[5:0], 0, 0, 1));
            chk("R9 kind no trap", rsp_kind, 2);
            chk(c < 16 ? "R8 bit7" : "R7 bit7", status_byte[7], c >= 16);
            chk(c < 16 ? "R8 acc" : "R7 acc", acc_iop, c >= 16);
            write_stat(8'h00, 0);
        end
    endtask

    task automatic t_trap();
        enable_bsun = 1'b1;
        send(6'h1F, 0, 0, 1);
        chk("R9 trap kind", rsp_kind, 3);
        chk("R9 trap true", rsp_true, 0);
        chk("R7 trap bit7", status_byte, 8'h80);
        write_stat(8'h00, 0);
        send(6'h11, 0, 1, 0);
        chk("R9 no nan result", rsp_kind, 2);
        chk("R6 SEQ zero", rsp_true, 1);
        send(6'h0F, 0, 0, 1);
        chk("R8 trap off group", rsp_kind, 2);
        chk("R8 status", status_byte, 8'h00);
        enable_bsun = 1'b0;
    endtask

    task automatic t_status();
        write_stat(8'h5A, 1);
        chk("R10 write loads", status_byte, 8'h5A);
        chk("R10 acc load", acc_iop, 1);
        send(6'h07, 1, 0, 0);
        chk("R10 held", status_byte, 8'h5A);
        @(negedge clk);
        pred_code = 6'h14; flag_nan = 1'b1; req_valid = 1'b1;
        stat_wr_en = 1'b1; stat_wr_data = 8'h00; acc_wr_data = 1'b0;
        @(negedge clk);
        req_valid = 1'b0; stat_wr_en = 1'b0;
        chk("R10 set beats write", status_byte, 8'h80);
        chk("R10 acc beats write", acc_iop, 1);
        write_stat(8'h00, 0);
        chk("R10 cleared", status_byte, 8'h00);
    endtask

    task automatic t_reserved();
        for (int c = 32; c < 64; c += 5) begin
            send(c[5:0], 0, 1, 1);
            chk("R11 kind", rsp_kind, 2);
            chk("R11 false", rsp_true, 0);
            chk("R11 no bit7", status_byte, 8'h00);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        #12 rst_n = 1'b1;
        t_reset();
        t_busy();
        t_pending();
        t_sweep_ordered();
        t_sweep_nan();
        t_trap();
        t_status();
        t_reserved();
        finish_run();
    end
endmodule